// File: doc/BRIEF.md
# At-Speed Capture Clock Controller

This block produces the single test clock that drives a design's scan flops. While scan enable is high, the block passes the slow clock supplied by the tester straight to its output, so scan chains shift at tester speed. When scan enable drops, a short shift register clocked by the fast internal clock sees the change. The first stages act as a synchronizer. Two later stages then open a high-speed enable window exactly two fast periods wide.

A clock gate built around an enable register on the falling edge of the fast clock passes exactly two full fast-clock pulses. The first pulse launches a transition and the second captures it at the functional frequency. After one burst the block stays quiet until scan enable has been raised and dropped again.

The shift depth, the stage that opens the window and the number of pulses are parameters. The defaults are five stages, window opening at stage index 2 and two pulses. The tester is expected to hold the slow clock low whenever it changes scan enable. It must keep scan enable low for at least six fast periods per capture, and high for at least five fast periods between captures.

Top module: `capclk_ctrl`

## Requirements
- R1: While scan_enable is 1 (and has been for at least three fast-clock rising edges), test_clk equals scan_clk at all times, and no fast-clock pulse reaches test_clk.
- R2: While rst_n is 0, and after rst_n returns to 1, test_clk shows no pulse until scan_enable has been 1 and then fallen. This holds even if reset is applied in the middle of a capture sequence.
- R3: With default parameters, the first capture pulse on test_clk begins at the 4th rising edge of fast_clk after scan_enable falls.
- R4: Each fall of scan_enable yields exactly two capture pulses on test_clk, on two consecutive rising edges of fast_clk.
- R5: Every capture pulse is a full fast-clock high phase (4 ns at 125 MHz) with no runt. The gate enable changes only while fast_clk is low.
- R6: Holding scan_enable low beyond the burst produces no further pulse. A new burst follows only after scan_enable returns to 1 for at least five fast periods and falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; leaves the controller in the spent state |
| scan_enable | input | 1 | 1 selects shift (slow clock), falling to 0 starts one capture burst |
| scan_clk | input | 1 | Slow shift clock from the tester |
| fast_clk | input | 1 | Fast internal clock used for at-speed capture |
| test_clk | output | 1 | Clock delivered to the scan flops |

## Verification
The bench drops scan enable at random phases of the fast clock. It checks that the first capture pulse lands on the fourth fast rising edge and the second exactly one period later. A design with a different synchronizer depth, or with a window of the wrong width, would show a shifted time or a pulse count of one or three. Each pulse width is measured: a gate whose enable is sampled on the wrong edge would clip a pulse into a runt. Scan enable is then held low long after the burst, and reset is applied mid-sequence. A controller that re-arms on its own, or that comes out of reset armed, would emit stray pulses there. Shift phases compare test_clk with scan_clk level by level, which catches any fast-clock leak into shift mode.

// File: rtl/capclk_ctrl.sv
module capclk_ctrl #(
  parameter int STAGES       = 5,
  parameter int LAUNCH_STAGE = 2,
  parameter int PULSES       = 2
) (
  input  logic rst_n,
  input  logic scan_enable,
  input  logic scan_clk,
  input  logic fast_clk,
  output logic test_clk
);
  localparam int STOP_STAGE = LAUNCH_STAGE + PULSES;

  logic [STAGES-1:0] cnt_sr;
  logic              hs_en;
  logic              en_neg;
  logic              gated;

  // ones mark "scan enable seen low"; reset leaves the chain full (spent)
  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) cnt_sr <= '1;
    else        cnt_sr <= {cnt_sr[STAGES-2:0], ~scan_enable};
  end

  assign hs_en = cnt_sr[LAUNCH_STAGE] & ~cnt_sr[STOP_STAGE];

  // enable updated only on the falling edge, so it is steady through each high phase
  always_ff @(negedge fast_clk or negedge rst_n) begin
    if (!rst_n) en_neg <= 1'b0;
    else        en_neg <= hs_en;
  end

  assign gated    = fast_clk & en_neg;
  assign test_clk = scan_enable ? scan_clk : gated;
endmodule

// File: rtl/capclk_ctrl_chk.sv
module capclk_ctrl_chk #(
  parameter int PULSES = 2
) (
  input logic fast_clk,
  input logic rst_n,
  input logic scan_enable,
  input logic hs_en,
  input logic en_neg
);
  logic [2:0] hi_cnt;
  logic [3:0] win_len;
  logic [1:0] bursts;
  logic       hs_q;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      win_len <= '0;
      bursts  <= '0;
      hs_q    <= 1'b0;
    end else begin
      hs_q    <= hs_en;
      hi_cnt  <= !scan_enable ? 3'd0 : (hi_cnt == 3'd7 ? hi_cnt : hi_cnt + 3'd1);
      win_len <= hs_en ? win_len + 4'd1 : 4'd0;
      if (scan_enable) bursts <= '0;
      else if (hs_en && !hs_q && bursts != 2'd3) bursts <= bursts + 2'd1;
    end
  end

  // R1: fast window closed once shift mode has settled
  p_shift_quiet_r1: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (hi_cnt >= 3'd3) |-> (!hs_en && !en_neg));

  // R3: the window only opens while scan enable is low
  p_open_low_r3: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $rose(hs_en) |-> !scan_enable);

  // R4: window length equals the pulse count
  p_window_len_r4: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $fell(hs_en) |-> (win_len == 4'(PULSES)));

  // R5: falling-edge enable matches the window at every rising edge
  p_gate_follow_r5: assert property (@(posedge fast_clk) disable iff (!rst_n)
    en_neg == hs_en);

  // R6: at most one window per low period of scan enable
  p_one_burst_r6: assert property (@(posedge fast_clk) disable iff (!rst_n)
    bursts <= 2'd1);
endmodule

bind capclk_ctrl capclk_ctrl_chk #(.PULSES(PULSES)) chk_i (
  .fast_clk    (fast_clk),
  .rst_n       (rst_n),
  .scan_enable (scan_enable),
  .hs_en       (hs_en),
  .en_neg      (en_neg)
);

// File: tb/capclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module capclk_ctrl_tb_top;
  logic rst_n = 1'b0;
  logic scan_enable = 1'b0;
  logic scan_clk = 1'b0;
  logic fast_clk = 1'b0;
  logic test_clk;

  int total = 0;
  int bad = 0;
  int n_pulse = 0;
  int cap_cnt = 0;
  realtime first_t = 0, second_t = 0, rise_t = 0, min_w = 100.0, tf = 0;

  localparam real PER = 8.0;
  localparam int  FIRST_EDGE = 4;

  always #4 fast_clk = ~fast_clk;

  capclk_ctrl dut_i (
    .rst_n       (rst_n),
    .scan_enable (scan_enable),
    .scan_clk    (scan_clk),
    .fast_clk    (fast_clk),
    .test_clk    (test_clk)
  );

  always @(posedge test_clk) begin
    rise_t = $realtime;
    if (scan_enable) n_pulse++;
    else begin
      if (cap_cnt == 0) first_t = $realtime;
      else if (cap_cnt == 1) second_t = $realtime;
      cap_cnt++;
    end
  end

  always @(negedge test_clk)
    if (!scan_enable && ($realtime - rise_t) < min_w) min_w = $realtime - rise_t;

  function automatic real edge_after(real t, int nth);
    int k;
    k = int'($floor((t - 4.0) / PER)) + 1;
    return 4.0 + PER * real'(k + nth - 1);
  endfunction

  task automatic chk(bit ok, string req, string what, real act, real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic do_shift(int n);
    int p0 = n_pulse;
    for (int i = 0; i < n; i++) begin
      #3 scan_clk = 1'b1;
      #2 chk(test_clk === 1'b1, "R1", "test_clk high with scan_clk", real'(test_clk), 1.0);
      #3 scan_clk = 1'b0;
      #2 chk(test_clk === 1'b0, "R1", "test_clk low with scan_clk", real'(test_clk), 0.0);
    end
    #20;
    chk(n_pulse - p0 == n, "R1", "shift pulse count", real'(n_pulse - p0), real'(n));
  endtask

  task automatic do_capture(int off, int off2);
    @(posedge fast_clk);
    #(off);
    cap_cnt = 0; first_t = 0; second_t = 0; min_w = 100.0;
    scan_enable = 1'b0;
    tf = $realtime;
    repeat (12) @(posedge fast_clk);
    #1;
    chk(cap_cnt == 2, "R4", "capture pulse count", real'(cap_cnt), 2.0);
    chk(first_t == edge_after(tf, FIRST_EDGE), "R3", "first pulse time", first_t,
        edge_after(tf, FIRST_EDGE));
    chk(second_t == edge_after(tf, FIRST_EDGE + 1), "R4", "second pulse time", second_t,
        edge_after(tf, FIRST_EDGE + 1));
    chk(min_w > 3.999 && min_w < 4.001, "R5", "pulse width", min_w, 4.0);
    repeat (30) @(posedge fast_clk);
    #1;
    chk(cap_cnt == 2, "R6", "no extra pulse while held low", real'(cap_cnt), 2.0);
    @(posedge fast_clk);
    #(off2);
    scan_enable = 1'b1;
    repeat (6) @(posedge fast_clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(posedge fast_clk);
    #1;
    chk(cap_cnt == 0 && test_clk === 1'b0, "R2", "quiet in reset", real'(cap_cnt), 0.0);
    #1 rst_n = 1'b1;
    repeat (20) @(posedge fast_clk);
    #1;
    chk(cap_cnt == 0, "R2", "no burst after reset release", real'(cap_cnt), 0.0);

    #1 scan_enable = 1'b1;
    repeat (6) @(posedge fast_clk);
    #2;
    do_shift(8);
    do_capture(3, 2);
    do_shift(1);
    do_capture(7, 5);

    // reset in the middle of the synchronizer phase
    @(posedge fast_clk);
    #2;
    cap_cnt = 0;
    scan_enable = 1'b0;
    repeat (2) @(posedge fast_clk);
    #2 rst_n = 1'b0;
    repeat (3) @(posedge fast_clk);
    #2 rst_n = 1'b1;
    repeat (20) @(posedge fast_clk);
    #1;
    chk(cap_cnt == 0, "R2", "no pulse after mid-sequence reset", real'(cap_cnt), 0.0);
    #1 scan_enable = 1'b1;
    repeat (6) @(posedge fast_clk);
    #2;
    do_shift(2);
    do_capture(1, 6);

    for (int r = 0; r < 12; r++) begin
      do_shift(1 + int'($urandom % 10));
      do_capture(1 + int'($urandom % 7), 1 + int'($urandom % 7));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule